// File: doc/BRIEF.md
# Gap-Interval Reader Command Decoder

This block turns a thresholded reader-field signal into command frames. The field input is high while the carrier is present and drops low during the short gaps that a reader keys into its carrier. After synchronization, the block counts carrier-period ticks between consecutive rising edges of the field. It sorts each count into one of four classes: noise, a 0 bit, a 1 bit, or too long to be a bit. Accepted bits are packed into a frame buffer.

When the tick count since the last rising edge grows past the end-of-frame limit, the current frame closes. If the frame holds at least one bit, its contents and bit count appear on the outputs together with a one-cycle valid pulse. The buffer is then emptied for the next command.

The running count since the last rising edge is always available on an output. A reply transmitter can use it to time the start of its answer.

Top module: `gap_cmd_decoder`

## Requirements
- R1: The field input passes through two synchronizer flops, and only its rising edges are used. `since_edge` returns to 0 after every rising edge and then counts one per `carrier_tick`.
- R2: An interval of fewer than 15 ticks between rising edges adds no bit. The edge still restarts the interval count.
- R3: An interval of 15 to 23 ticks inclusive appends a 0 bit.
- R4: An interval of 24 to 40 ticks inclusive appends a 1 bit.
- R5: A frame ends when `since_edge` steps from 40 to 41. If it holds at least one bit, `frame_valid` pulses high for exactly one clock and `since_edge` reads 41 in that clock. In the same clock, `frame_len` gives the bit count and `frame_data` gives the contents.
- R6: A frame that ends holding zero bits produces no `frame_valid` pulse.
- R7: The first interval that ends after a timeout, or after reset, is ignored whatever its length.
- R8: Bit number k of a frame (k = 0 first received) is placed at `frame_data[8*(k/8) + 7 - (k%8)]`. Byte j therefore occupies `frame_data[8*j+7 : 8*j]`, and its first bit is in the most significant position.
- R9: The buffer holds 80 bits. Bits that arrive after the 80th in a frame are discarded, and `frame_len` then reads 80.
- R10: After a frame is delivered, the next frame starts empty: unwritten positions read 0 and the count restarts from 0.
- R11: `since_edge` saturates at 1023 and does not wrap.
- R12: `frame_data` and `frame_len` hold their values between `frame_valid` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| field_in | input | 1 | Thresholded carrier presence, asynchronous |
| carrier_tick | input | 1 | One-clock pulse per carrier period |
| frame_data | output | 80 | Delivered frame contents, packed as in R8 |
| frame_len | output | 7 | Number of bits in the delivered frame |
| frame_valid | output | 1 | One-clock pulse when a frame is delivered |
| since_edge | output | 10 | Carrier ticks since the last rising edge, saturating |

## Verification
The hardest situation to reach is an edge that arrives just after a timeout. Its interval may be exactly 41 ticks, so it is too long by only one tick. It must be dropped because of the timeout rule, not merely because of its length. The stimulus closes a frame with an interval of exactly 41 ticks and follows it with a valid 0-bit spacing. The scoreboard expects two separate frames: one carrying the earlier 1 bit and one carrying only the 0. This shows both the delivery at the 41st tick and the discard of the edge that follows it. Rising edges are always placed at the same phase after a tick, so every interval is an exact tick count and the window edges 14/15, 23/24 and 40/41 can each be hit.

// File: rtl/gcd_pkg.sv
// Shared types for the gap-interval command decoder.
// Assumes nothing beyond IEEE 1800-2017 packages.
package gcd_pkg;

    // Class of one measured edge-to-edge interval.
    typedef enum logic [1:0] {
        GAP_NOISE = 2'd0,
        GAP_ZERO  = 2'd1,
        GAP_ONE   = 2'd2,
        GAP_LONG  = 2'd3
    } gap_kind_t;

endpackage

// File: rtl/gcd_edge_sync.sv
// Synchronizes the asynchronous field level into the clock domain and
// flags each rising edge for one clock.
// Assumes STAGES >= 2 and the input is a slow level compared to clk.
module gcd_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic field_in,
    output logic rise
);

    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Shift the raw level through the synchronizer chain and keep one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], field_in};
            prev_q <= sync_q[STAGES-1];
        end
    end

    // A rising edge is a high synchronized level following a low one.
    always_comb begin
        rise = sync_q[STAGES-1] & ~prev_q;
    end

endmodule

// File: rtl/gcd_interval_timer.sv
// Counts carrier ticks since the last rising edge, saturating at the top
// of its range, and flags the tick on which the count passes the
// end-of-frame limit.
// Assumes T_EOF + 1 fits in CNT_W bits.
module gcd_interval_timer #(
    parameter int CNT_W = 10,
    parameter int T_EOF = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    input  logic             tick,
    output logic [CNT_W-1:0] count,
    output logic             eof_fire
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] EOF_AT  = CNT_W'(T_EOF);

    logic [CNT_W-1:0] count_q;

    // Restart on every rising edge, otherwise count ticks up to saturation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (rise) begin
            count_q <= '0;
        end else if (tick && (count_q != CNT_MAX)) begin
            count_q <= count_q + CNT_W'(1);
        end
    end

    // End of frame is the single tick that moves the count past the limit.
    always_comb begin
        eof_fire = tick && !rise && (count_q == EOF_AT);
        count    = count_q;
    end

endmodule

// File: rtl/gcd_gap_classifier.sv
// Sorts a finished interval into noise, 0 bit, 1 bit or overlong.
// Assumes T0_MIN < T1_MIN <= T_EOF.
module gcd_gap_classifier
    import gcd_pkg::*;
#(
    parameter int CNT_W  = 10,
    parameter int T0_MIN = 15,
    parameter int T1_MIN = 24,
    parameter int T_EOF  = 40
) (
    input  logic [CNT_W-1:0] interval,
    output gap_kind_t        kind
);

    localparam logic [CNT_W-1:0] LIM0 = CNT_W'(T0_MIN);
    localparam logic [CNT_W-1:0] LIM1 = CNT_W'(T1_MIN);
    localparam logic [CNT_W-1:0] LIMX = CNT_W'(T_EOF);

    // Compare the interval against the window limits, longest first.
    always_comb begin
        if (interval > LIMX) begin
            kind = GAP_LONG;
        end else if (interval >= LIM1) begin
            kind = GAP_ONE;
        end else if (interval >= LIM0) begin
            kind = GAP_ZERO;
        end else begin
            kind = GAP_NOISE;
        end
    end

endmodule

// File: rtl/gcd_frame_assembler.sv
// Packs decoded bits first-bit-at-byte-MSB into a frame buffer, closes
// the frame on timeout, presents it with a one-clock valid pulse and then
// clears the buffer. Discards the first interval after reset or timeout.
// Assumes FRAME_BITS is a multiple of 8.
module gcd_frame_assembler
    import gcd_pkg::*;
#(
    parameter int FRAME_BITS = 80,
    parameter int LEN_W      = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rise,
    input  gap_kind_t             kind,
    input  logic                  eof_fire,
    output logic [FRAME_BITS-1:0] frame_data,
    output logic [LEN_W-1:0]      frame_len,
    output logic                  frame_valid
);

    localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(FRAME_BITS);

    logic [FRAME_BITS-1:0] buf_q;
    logic [LEN_W-1:0]      pos_q;
    logic                  skip_q;
    logic [FRAME_BITS-1:0] out_data_q;
    logic [LEN_W-1:0]      out_len_q;
    logic                  out_valid_q;
    logic                  take_bit;
    logic                  bit_val;
    logic [LEN_W-1:0]      wr_idx;

    // Decide whether this edge contributes a bit and where it lands.
    always_comb begin
        take_bit = rise && !skip_q && (pos_q != LEN_CAP) &&
                   ((kind == GAP_ZERO) || (kind == GAP_ONE));
        bit_val  = (kind == GAP_ONE);
        wr_idx   = pos_q ^ LEN_W'(7);
    end

    // Buffer and count: fill on accepted bits, clear when a frame closes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q <= '0;
            pos_q <= '0;
        end else if (eof_fire) begin
            buf_q <= '0;
            pos_q <= '0;
        end else if (take_bit) begin
            buf_q[wr_idx] <= bit_val;
            pos_q         <= pos_q + LEN_W'(1);
        end
    end

    // Skip flag: armed by reset and timeout, consumed by the next edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            skip_q <= 1'b1;
        end else if (eof_fire) begin
            skip_q <= 1'b1;
        end else if (rise) begin
            skip_q <= 1'b0;
        end
    end

    // Output register: capture a non-empty frame and pulse valid once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data_q  <= '0;
            out_len_q   <= '0;
            out_valid_q <= 1'b0;
        end else begin
            out_valid_q <= 1'b0;
            if (eof_fire && (pos_q != '0)) begin
                out_data_q  <= buf_q;
                out_len_q   <= pos_q;
                out_valid_q <= 1'b1;
            end
        end
    end

    // Drive ports from the output register.
    always_comb begin
        frame_data  = out_data_q;
        frame_len   = out_len_q;
        frame_valid = out_valid_q;
    end

endmodule

// File: rtl/gap_cmd_decoder.sv
// Top level: decodes reader commands from the spacing of rising edges
// on a thresholded field signal, measured in carrier ticks.
// Assumes carrier_tick is a one-clock pulse, at most one per clock.
module gap_cmd_decoder #(
    parameter int FRAME_BITS = 80,
    parameter int CNT_W      = 10,
    parameter int SYNC_STAGES = 2,
    parameter int T0_MIN     = 15,
    parameter int T1_MIN     = 24,
    parameter int T_EOF      = 40,
    localparam int LEN_W     = $clog2(FRAME_BITS + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  field_in,
    input  logic                  carrier_tick,
    output logic [FRAME_BITS-1:0] frame_data,
    output logic [LEN_W-1:0]      frame_len,
    output logic                  frame_valid,
    output logic [CNT_W-1:0]      since_edge
);

    import gcd_pkg::*;

    logic             rise;
    logic             eof_fire;
    logic [CNT_W-1:0] count;
    gap_kind_t        kind;

    gcd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .field_in (field_in),
        .rise     (rise)
    );

    gcd_interval_timer #(.CNT_W(CNT_W), .T_EOF(T_EOF)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise     (rise),
        .tick     (carrier_tick),
        .count    (count),
        .eof_fire (eof_fire)
    );

    gcd_gap_classifier #(
        .CNT_W(CNT_W), .T0_MIN(T0_MIN), .T1_MIN(T1_MIN), .T_EOF(T_EOF)
    ) u_class (
        .interval (count),
        .kind     (kind)
    );

    gcd_frame_assembler #(.FRAME_BITS(FRAME_BITS), .LEN_W(LEN_W)) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .rise        (rise),
        .kind        (kind),
        .eof_fire    (eof_fire),
        .frame_data  (frame_data),
        .frame_len   (frame_len),
        .frame_valid (frame_valid)
    );

    // Export the interval count for reply scheduling.
    always_comb begin
        since_edge = count;
    end

endmodule

// File: rtl/gap_cmd_decoder_checker.sv
// Port-level temporal checks for the gap-interval command decoder.
module gap_cmd_decoder_checker #(
    parameter int FRAME_BITS = 80,
    parameter int CNT_W      = 10,
    parameter int T_EOF      = 40,
    parameter int LEN_W      = 7
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [FRAME_BITS-1:0] frame_data,
    input logic [LEN_W-1:0]      frame_len,
    input logic                  frame_valid,
    input logic [CNT_W-1:0]      since_edge
);

    assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> !frame_valid);

    assert_valid_at_timeout_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> (since_edge == CNT_W'(T_EOF + 1)));

    assert_len_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> (frame_len != '0));

    assert_len_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> (frame_len <= LEN_W'(FRAME_BITS)));

    assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((since_edge == '0) || $stable(since_edge) ||
                  (since_edge == $past(since_edge) + CNT_W'(1))));

    assert_no_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (since_edge == {CNT_W{1'b1}}) |=> ((since_edge == {CNT_W{1'b1}}) || (since_edge == '0)));

    assert_hold_data_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_valid |-> ($stable(frame_data) && $stable(frame_len)));

endmodule

bind gap_cmd_decoder gap_cmd_decoder_checker #(
    .FRAME_BITS (FRAME_BITS),
    .CNT_W      (CNT_W),
    .T_EOF      (T_EOF),
    .LEN_W      (LEN_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_data  (frame_data),
    .frame_len   (frame_len),
    .frame_valid (frame_valid),
    .since_edge  (since_edge)
);

// File: tb/gap_cmd_decoder_test.sv
module gap_cmd_decoder_test;

    localparam int FB    = 80;
    localparam int CW    = 10;
    localparam int LW    = 7;
    localparam int TDIV  = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          field_in = 1'b1;
    logic          carrier_tick = 1'b0;
    logic [FB-1:0] frame_data;
    logic [LW-1:0] frame_len;
    logic          frame_valid;
    logic [CW-1:0] since_edge;

    int checks = 0;
    int errors = 0;
    int frames_seen = 0;
    int frames_exp = 0;
    int tdiv = 0;
    bit done = 1'b0;

    logic [LW+FB-1:0] exp_q[$];
    logic [FB-1:0]    cur_data = '0;
    int               cur_len = 0;
    bit               skip_next = 1'b1;

    gap_cmd_decoder uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .field_in     (field_in),
        .carrier_tick (carrier_tick),
        .frame_data   (frame_data),
        .frame_len    (frame_len),
        .frame_valid  (frame_valid),
        .since_edge   (since_edge)
    );

    always #4 clk = ~clk;

    // Carrier tick: one clock in TDIV, changed away from the active edge.
    always @(negedge clk) begin
        tdiv = (tdiv + 1) % TDIV;
        carrier_tick <= (tdiv == 0);
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            while (!carrier_tick) @(posedge clk);
        end
    endtask

    task automatic rise_pulse();
        @(negedge clk) field_in = 1'b0;
        repeat (2) @(negedge clk);
        field_in = 1'b1;
    endtask

    task automatic add_bit(input bit b);
        if (cur_len < FB) begin
            cur_data[8*(cur_len/8) + 7 - (cur_len%8)] = b;   // R8 packing
            cur_len++;
        end                                                 // R9 cap
    endtask

    // Close the modelled frame: queue it when non-empty (R5, R6), reset model (R10).
    task automatic finish_frame();
        if (cur_len > 0) begin
            exp_q.push_back({LW'(cur_len), cur_data});
            frames_exp++;
        end
        cur_len = 0;
        cur_data = '0;
        skip_next = 1'b1;                                   // R7
    endtask

    // Driver: one rising edge n ticks after the previous one.
    task automatic do_interval(input int n);
        if (n > 40) finish_frame();
        wait_ticks(n);
        rise_pulse();
        if (skip_next) skip_next = 1'b0;
        else if (n >= 15 && n <= 23) add_bit(1'b0);         // R3
        else if (n >= 24 && n <= 40) add_bit(1'b1);         // R4
                                                            // R2: shorter ones dropped
    endtask

    task automatic end_frame();
        finish_frame();
        wait_ticks(42);
        repeat (3) @(negedge clk);
    endtask

    // Monitor: pop and compare on every delivered frame.
    always @(negedge clk) begin
        if (rst_n && frame_valid) begin
            frames_seen++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R6 unexpected frame", longint'(frame_len), 0);
            end else begin
                logic [LW+FB-1:0] e;
                e = exp_q.pop_front();
                check(frame_len == e[LW+FB-1:FB], "R5 frame_len", longint'(frame_len),
                      longint'(e[LW+FB-1:FB]));
                checks++;
                if (frame_data != e[FB-1:0]) begin
                    errors++;
                    $display("FAIL R8 frame_data: actual %h expected %h", frame_data, e[FB-1:0]);
                end
            end
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        check(frame_valid == 1'b0, "R5 reset valid", frame_valid, 0);
        check(frame_len == '0, "R12 reset len", frame_len, 0);
        check(since_edge == '0, "R1 reset since_edge", since_edge, 0);
        rst_n = 1'b1;
        // Idle past the timeout; empty frame closes silently, skip armed.
        wait_ticks(45);
        skip_next = 1'b1;

        // Frame A: window boundaries, noise between bits.
        do_interval(3);
        do_interval(15); do_interval(23); do_interval(24); do_interval(40);
        do_interval(14); do_interval(20);
        repeat (3) @(negedge clk);
        check(since_edge == '0, "R1 cleared at edge", since_edge, 0);
        wait_ticks(10);
        @(negedge clk);
        check(since_edge == CW'(10), "R1 counts ticks", since_edge, 10);
        end_frame();

        // Saturation during long idle.
        wait_ticks(1030);
        @(negedge clk);
        check(since_edge == {CW{1'b1}}, "R11 saturation", since_edge, 1023);

        // Frame B: 85 bits, only 80 kept.
        do_interval(2);
        for (int k = 0; k < 85; k++) do_interval((k % 3 == 0) ? 30 : 18);
        end_frame();

        // Frame C: noise only, no delivery expected.
        do_interval(2);
        do_interval(5); do_interval(10); do_interval(14);
        end_frame();

        // Frame D/E: 41-tick interval closes D; its edge is ignored; then a 0.
        do_interval(4);
        do_interval(25);
        do_interval(41);
        do_interval(22);
        end_frame();

        repeat (10) @(negedge clk);
        check(exp_q.size() == 0, "R5 all frames delivered", exp_q.size(), 0);
        check(frames_seen == frames_exp, "R6 frame count", frames_seen, frames_exp);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule